// File: doc/BRIEF.md
# Host interrupt request generator

This block produces the request line that asks an external host for service, either as an interrupt or as a transfer request to a DMA engine. There are two data paths, receive and transmit. Each has a request-enable bit and a ready flag, and a path counts as qualified when both are set and DMA mode is off. The request is raised when a qualified path exists that has no host access open against it.

A mode bit selects the shape of the request. In pulse mode, a new eligible condition starts a pulse whose length in clocks comes from a programmable width value. In hold mode, the request is a level. It drops when the host begins an access to the path that raised it, when that path is masked, or when DMA mode is switched on. A host access is bracketed by strobes. A read start opens an access on the receive path, a write start opens one on the transmit path, and an access-end strobe closes one. Once the access closes, a path that is still qualified raises the request again in either mode. A drive bit selects a push-pull pin or an open-drain pin. The open-drain pin is modelled as a low-driving output with a separate enable.

Top module: `hirq_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the request is inactive and the pulse counter is cleared. In push-pull mode this means `irq_pin`=1 and `irq_oe`=1.
- R2: The request never becomes active while no path is qualified. A path is qualified when its enable and ready are both 1 and `dma_en`=0.
- R3: In pulse mode (`hold_mode`=0), each new eligible condition produces one active pulse of exactly `pulse_width` clocks, starting at the next clock edge. A width of 0 is treated as 1.
- R4: In pulse mode, a condition that stays eligible does not start another pulse. Switching from hold mode to pulse mode while eligible does not start a pulse either.
- R5: In hold mode (`hold_mode`=1), the request is active one edge after a path becomes eligible and stays active while one is. `rd_start` opens an access on the receive path and `wr_start` opens one on the transmit path. The request drops at the edge that samples the start strobe, unless the other path is still eligible.
- R6: In hold mode, the request drops at the next edge when the qualifying enable is cleared or when `dma_en` is set.
- R7: When `acc_end` closes an open access, a path that is still qualified makes the request active at that same edge. In hold mode this is the level; in pulse mode it is a new pulse.
- R8: If both accesses are open, `acc_end` closes the receive-path access first. A start strobe sampled in the same cycle as `acc_end` opens its access.
- R9: With `open_drain`=0, `irq_pin` = NOT active and `irq_oe`=1. With `open_drain`=1, `irq_pin`=0 and `irq_oe` = active.
- R10: In pulse mode, setting `dma_en` ends a running pulse at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req_en | input | 1 | Receive-path request enable |
| tx_req_en | input | 1 | Transmit-path request enable |
| rx_ready | input | 1 | Receive data available for the host |
| tx_ready | input | 1 | Transmit side can accept data |
| hold_mode | input | 1 | 1 = held level, 0 = counted pulse |
| dma_en | input | 1 | DMA mode, suppresses the request |
| open_drain | input | 1 | 1 = open-drain pin, 0 = push-pull |
| pulse_width | input | CNT_W | Pulse length in clocks (0 means 1) |
| rd_start | input | 1 | Host read access begins (receive path) |
| wr_start | input | 1 | Host write access begins (transmit path) |
| acc_end | input | 1 | Host access ends |
| irq_pin | output | 1 | Request pin value, active low |
| irq_oe | output | 1 | Pin output enable |

## Verification
The closing of one access and the opening of another can fall in the same clock. The bench provokes this in hold mode by pulsing `acc_end` and `wr_start` together while a receive access is open. It expects the request to come straight back through the receive path. After the receive path is masked, it expects the request to stay inactive, which shows that the transmit access really opened. It also puts `acc_end` with both accesses open and confirms that the receive access is the one that closed.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    // Path indices: receive is index 0 and has priority on access close.
    localparam int NPATH   = 2;
    localparam int PATH_RX = 0;
    localparam int PATH_TX = 1;

    typedef logic [NPATH-1:0] pvec_t;

    typedef enum logic {
        SHAPE_PULSE = 1'b0,
        SHAPE_HOLD  = 1'b1
    } shape_e;

    typedef enum logic {
        DRV_PUSH = 1'b0,
        DRV_OPEN = 1'b1
    } drv_e;

    typedef struct packed {
        logic pin;
        logic oe;
    } pin_t;

    // Lowest set index of a path vector, as a one-hot vector.
    function automatic pvec_t first_set(input pvec_t v);
        pvec_t r;
        logic  found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NPATH; i++) begin
            if (v[i] && !found) begin
                r[i]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hirq_access.sv
module hirq_access
    import hirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pvec_t start,
    input  logic  acc_end,
    output pvec_t busy_nxt
);
    pvec_t busy_q;
    pvec_t close_v;

    // An access end closes the highest priority open access.
    always_comb begin
        close_v  = acc_end ? first_set(busy_q) : '0;
        busy_nxt = (busy_q & ~close_v) | start;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= busy_nxt;
    end
endmodule

// File: rtl/hirq_qual.sv
module hirq_qual
    import hirq_pkg::*;
(
    input  pvec_t en,
    input  pvec_t rdy,
    input  logic  dma_en,
    input  pvec_t busy_nxt,
    output logic  elig
);
    pvec_t qual;
    pvec_t live;

    for (genvar i = 0; i < NPATH; i++) begin : g_path
        assign qual[i] = en[i] & rdy[i] & ~dma_en;
        assign live[i] = qual[i] & ~busy_nxt[i];
    end

    assign elig = |live;
endmodule

// File: rtl/hirq_shape.sv
module hirq_shape
    import hirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  shape_e           shape,
    input  logic             dma_en,
    input  logic             elig,
    input  logic [CNT_W-1:0] width,
    output logic             act
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load;
    logic             elig_q;
    logic             lvl_q;
    shape_e           shape_q;
    logic             rise;

    assign rise = elig & ~elig_q;
    assign load = (width == '0) ? ONE : width;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            elig_q  <= 1'b0;
            lvl_q   <= 1'b0;
            shape_q <= SHAPE_PULSE;
        end else begin
            elig_q  <= elig;
            shape_q <= shape;
            lvl_q   <= (shape == SHAPE_HOLD) & elig;
            if (shape == SHAPE_HOLD || dma_en) cnt_q <= '0;
            else if (rise)                     cnt_q <= load;
            else if (cnt_q != '0)              cnt_q <= cnt_q - ONE;
        end
    end

    assign act = (shape_q == SHAPE_HOLD) ? lvl_q : (cnt_q != '0);
endmodule

// File: rtl/hirq_drive.sv
module hirq_drive
    import hirq_pkg::*;
(
    input  logic act,
    input  drv_e mode,
    output pin_t drv
);
    always_comb begin
        if (mode == DRV_OPEN) begin
            drv.pin = 1'b0;
            drv.oe  = act;
        end else begin
            drv.pin = ~act;
            drv.oe  = 1'b1;
        end
    end
endmodule

// File: rtl/hirq_gen.sv
module hirq_gen
    import hirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_req_en,
    input  logic             tx_req_en,
    input  logic             rx_ready,
    input  logic             tx_ready,
    input  logic             hold_mode,
    input  logic             dma_en,
    input  logic             open_drain,
    input  logic [CNT_W-1:0] pulse_width,
    input  logic             rd_start,
    input  logic             wr_start,
    input  logic             acc_end,
    output logic             irq_pin,
    output logic             irq_oe
);
    pvec_t en_v, rdy_v, start_v, busy_nxt;
    logic  elig, act;
    pin_t  drv;

    always_comb begin
        en_v[PATH_RX]    = rx_req_en;
        en_v[PATH_TX]    = tx_req_en;
        rdy_v[PATH_RX]   = rx_ready;
        rdy_v[PATH_TX]   = tx_ready;
        start_v[PATH_RX] = rd_start;
        start_v[PATH_TX] = wr_start;
    end

    hirq_access u_access (
        .clk      (clk),
        .rst      (rst),
        .start    (start_v),
        .acc_end  (acc_end),
        .busy_nxt (busy_nxt)
    );

    hirq_qual u_qual (
        .en       (en_v),
        .rdy      (rdy_v),
        .dma_en   (dma_en),
        .busy_nxt (busy_nxt),
        .elig     (elig)
    );

    hirq_shape #(.CNT_W(CNT_W)) u_shape (
        .clk    (clk),
        .rst    (rst),
        .shape  (hold_mode ? SHAPE_HOLD : SHAPE_PULSE),
        .dma_en (dma_en),
        .elig   (elig),
        .width  (pulse_width),
        .act    (act)
    );

    hirq_drive u_drive (
        .act  (act),
        .mode (open_drain ? DRV_OPEN : DRV_PUSH),
        .drv  (drv)
    );

    assign irq_pin = drv.pin;
    assign irq_oe  = drv.oe;
endmodule

// File: rtl/hirq_gen_chk.sv
module hirq_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_req_en,
    input logic             tx_req_en,
    input logic             rx_ready,
    input logic             tx_ready,
    input logic             hold_mode,
    input logic             dma_en,
    input logic             open_drain,
    input logic [CNT_W-1:0] pulse_width,
    input logic             rd_start,
    input logic             wr_start,
    input logic             acc_end,
    input logic             irq_pin,
    input logic             irq_oe
);
    logic active;
    assign active = open_drain ? irq_oe : ~irq_pin;

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !active);

    // R2
    a_r2_dma_idle: assert property (@(posedge clk) disable iff (rst)
        dma_en |=> !active);

    // R6
    a_r6_hold_masked: assert property (@(posedge clk) disable iff (rst)
        (hold_mode && !(rx_req_en && rx_ready) && !(tx_req_en && tx_ready))
        |=> !active);

    // R5
    a_r5_read_drops: assert property (@(posedge clk) disable iff (rst)
        (hold_mode && rd_start && !(tx_req_en && tx_ready)) |=> !active);

    // R9
    a_r9_od_never_high: assert property (@(posedge clk) disable iff (rst)
        open_drain |-> !irq_pin);

    // R9
    a_r9_push_always_on: assert property (@(posedge clk) disable iff (rst)
        !open_drain |-> irq_oe);
endmodule

bind hirq_gen hirq_gen_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/hirq_gen_test.sv
`timescale 1ns/1ps
module hirq_gen_test;
    localparam int CNT_W = 8;
    localparam int NV    = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_req_en = 0, tx_req_en = 0, rx_ready = 0, tx_ready = 0;
    logic hold_mode = 0, dma_en = 0, open_drain = 0;
    logic [CNT_W-1:0] pulse_width = '0;
    logic rd_start = 0, wr_start = 0, acc_end = 0;
    logic irq_pin, irq_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hirq_gen #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst),
        .rx_req_en(rx_req_en), .tx_req_en(tx_req_en),
        .rx_ready(rx_ready), .tx_ready(tx_ready),
        .hold_mode(hold_mode), .dma_en(dma_en), .open_drain(open_drain),
        .pulse_width(pulse_width),
        .rd_start(rd_start), .wr_start(wr_start), .acc_end(acc_end),
        .irq_pin(irq_pin), .irq_oe(irq_oe)
    );

    // Flags: hold od dma txen rxen txr rxr rd wr end | width | req | 00 pin oe
    localparam logic [21:0] VEC [NV] = '{
        {10'b0000000000, 4'd3, 4'd2,  4'b0011}, // R2 idle
        {10'b0000100000, 4'd3, 4'd2,  4'b0011}, // R2 not ready
        {10'b0010101000, 4'd3, 4'd2,  4'b0011}, // R2 dma blocks
        {10'b0000101000, 4'd3, 4'd3,  4'b0001}, // R3 pulse start
        {10'b0000101000, 4'd3, 4'd4,  4'b0001}, // R4
        {10'b0000101000, 4'd3, 4'd3,  4'b0001}, // R3 third clock
        {10'b0000101000, 4'd3, 4'd4,  4'b0011}, // R4 ends, no repeat
        {10'b0000101000, 4'd3, 4'd4,  4'b0011}, // R4
        {10'b0000001000, 4'd3, 4'd2,  4'b0011}, // R2 masked
        {10'b0000101000, 4'd0, 4'd3,  4'b0001}, // R3 width 0 -> 1
        {10'b0000101000, 4'd0, 4'd3,  4'b0011}, // R3
        {10'b1000101000, 4'd0, 4'd5,  4'b0001}, // R5 hold level
        {10'b1000101100, 4'd0, 4'd5,  4'b0011}, // R5 read start drops
        {10'b1000101000, 4'd0, 4'd5,  4'b0011}, // R5 access open
        {10'b1000101001, 4'd0, 4'd7,  4'b0001}, // R7 re-arm
        {10'b1000101000, 4'd0, 4'd7,  4'b0001}, // R7
        {10'b1010101000, 4'd0, 4'd6,  4'b0011}, // R6 dma drop
        {10'b1000101000, 4'd0, 4'd6,  4'b0001}, // R6
        {10'b1000001000, 4'd0, 4'd6,  4'b0011}, // R6 mask drop
        {10'b1000101000, 4'd0, 4'd5,  4'b0001}, // R5
        {10'b1100101000, 4'd0, 4'd9,  4'b0001}, // R9 od active
        {10'b1100001000, 4'd0, 4'd9,  4'b0000}, // R9 od released
        {10'b1001111000, 4'd0, 4'd8,  4'b0001}, // R8 both qualified
        {10'b1001111100, 4'd0, 4'd8,  4'b0001}, // R8 rx open, tx holds
        {10'b1001111010, 4'd0, 4'd8,  4'b0011}, // R8 both open
        {10'b1001111001, 4'd0, 4'd8,  4'b0001}, // R8 rx closes first
        {10'b1001011000, 4'd0, 4'd8,  4'b0011}, // R8 tx still open
        {10'b1001011001, 4'd0, 4'd7,  4'b0001}, // R7 tx closes
        {10'b0001011000, 4'd2, 4'd4,  4'b0011}, // R4 mode switch
        {10'b0001011010, 4'd2, 4'd7,  4'b0011}, // R7 write opens
        {10'b0001011000, 4'd2, 4'd7,  4'b0011}, // R7
        {10'b0001011001, 4'd2, 4'd7,  4'b0001}, // R7 pulse re-arm
        {10'b0001011000, 4'd2, 4'd7,  4'b0001}, // R7
        {10'b0001011000, 4'd2, 4'd3,  4'b0011}, // R3
        {10'b0000011000, 4'd2, 4'd2,  4'b0011}, // R2
        {10'b0001011000, 4'd2, 4'd3,  4'b0001}, // R3
        {10'b0011011000, 4'd2, 4'd10, 4'b0011}, // R10 dma aborts
        {10'b0001011000, 4'd2, 4'd10, 4'b0001}, // R10 new pulse
        {10'b0001011000, 4'd2, 4'd3,  4'b0001}, // R3
        {10'b0001011000, 4'd2, 4'd4,  4'b0011}  // R4
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if ({irq_pin, irq_oe} !== exp) begin
            errors++;
            $display("FAIL %s: pin/oe actual %b%b expected %b", req,
                     irq_pin, irq_oe, exp);
        end
    endtask

    task automatic apply(input logic [21:0] v);
        {hold_mode, open_drain, dma_en, tx_req_en, rx_req_en,
         tx_ready, rx_ready, rd_start, wr_start, acc_end} = v[21:12];
        pulse_width = {{(CNT_W-4){1'b0}}, v[11:8]};
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        tick();
        tick();
        check("R1 in reset", 2'b11);
        rst = 1'b0;
        tick();
        check("R1 after reset", 2'b11);

        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i]);
            tick();
            tag = $sformatf("R%0d vec %0d", VEC[i][7:4], i);
            check(tag, VEC[i][1:0]);
        end

        // R3: full-width pulse counted at the port
        apply(22'd0);
        tick();
        tick();
        rx_req_en = 1; rx_ready = 1; pulse_width = 8'd255;
        n = 0;
        for (int k = 0; k < 300; k++) begin
            tick();
            if (!irq_pin) n++;
        end
        checks++;
        if (n != 255) begin
            errors++;
            $display("FAIL R3 width 255: actual %0d expected 255", n);
        end

        // R1: reset in the middle of a pulse
        rx_req_en = 0;
        tick();
        rx_req_en = 1; pulse_width = 8'd10;
        tick();
        check("R1 pulse running", 2'b01);
        rst = 1'b1;
        tick();
        check("R1 reset cuts pulse", 2'b11);
        apply(22'd0);
        tick();
        rst = 1'b0;
        tick();
        check("R1 quiet after release", 2'b11);

        // R8: access end and write start in the same cycle
        hold_mode = 1; rx_req_en = 1; rx_ready = 1; tx_ready = 1;
        rd_start = 1;
        tick();
        check("R5 read opens", 2'b11);
        rd_start = 0;
        tick();
        check("R5 rx access held", 2'b11);
        acc_end = 1; wr_start = 1; tx_req_en = 1;
        tick();
        check("R8 end and write together", 2'b01);
        acc_end = 0; wr_start = 0; rx_req_en = 0;
        tick();
        check("R8 write access open", 2'b11);
        acc_end = 1;
        tick();
        check("R7 tx re-arm", 2'b01);
        acc_end = 0;
        tick();

        finish_run();
    end
endmodule